// File: doc/BRIEF.md
# TV Horizontal/Vertical Countdown Divider

This block turns a clock running at 32 times the line rate into the line-rate and field-rate timing of a raster display. A free-running line divider issues an enable at twice the line rate and a square horizontal drive wave at the line rate. A half-line field counter steps on that enable. It starts each field from a preset of 20, which keeps its terminal values in line with the usual field count. From the counter the block decodes a field-start strobe, a ramp charge pulse and a vertical blanking pulse.

Two modes exist. In standard mode the field is always 525 half-lines long. The integrated vertical sync strobe is then only compared against the end of the field, and the result appears on a coincidence output. In non-synchronous mode the field follows the sync strobe. Strobes that arrive early in the field are rejected as noise. When sync is absent, the field runs long (684 half-lines) so that lock is found quickly once sync returns. The blanking width in this mode comes from an input that is sampled at every field start.

Top module: `tv_countdown`

## Requirements
- R1: `hl_tick` is a one-clock pulse that repeats every 16 clocks.
- R2: `h_drive` has a period of 32 clocks and is high for 16 of them.
- R3: With `std_mode`=1 the field counter starts at 20 and reloads after half-line 544. `field_start` is a one-clock pulse that repeats every 8400 clocks.
- R4: With `std_mode`=1 a `vsync_in` strobe never restarts the field. The period stays 8400 clocks wherever the strobe falls.
- R5: With `std_mode`=0 and no strobe, the field period is 10944 clocks (684 half-lines).
- R6: With `std_mode`=0, a strobe sampled more than 7872 clocks after the field start restarts the field. `field_start` then pulses one clock after the sampling edge. A strobe sampled 7872 clocks or fewer after the field start is ignored.
- R7: `ramp_pulse` is high for 192 clocks (12 half-lines) at the start of every field.
- R8: With `std_mode`=1, `v_blank` is high for 608 clocks (38 half-lines) at the start of every field.
- R9: With `std_mode`=0, `v_blank` is high for `ns_blank_hl` × 16 clocks. `ns_blank_hl` is sampled at each field start.
- R10: `coinc` pulses for one clock after a strobe is sampled while the counter sits on half-line 544 or half-line 20. It stays low for a strobe sampled at any other time.
- R11: While `rst` is high, `hl_tick`, `field_start`, `coinc`, `ramp_pulse` and `v_blank` are low and `h_drive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 32 times the line rate |
| rst | input | 1 | Synchronous reset, active high |
| std_mode | input | 1 | 1 = standard fixed-length fields, 0 = non-synchronous |
| vsync_in | input | 1 | Integrated vertical sync strobe, one clock |
| ns_blank_hl | input | 8 | Blanking width in half-lines for non-synchronous mode |
| hl_tick | output | 1 | Twice-line-rate enable |
| h_drive | output | 1 | Line-rate horizontal drive |
| field_start | output | 1 | One-clock strobe at every field reload |
| ramp_pulse | output | 1 | Ramp charge pulse at the start of the field |
| v_blank | output | 1 | Vertical blanking pulse |
| coinc | output | 1 | Sync-to-terminal coincidence strobe |

## Verification
The bench measures field periods and pulse widths in clocks between `field_start` strobes.

- **Hold-off boundary.** It places a non-synchronous strobe exactly at 7872 and at 7873 clocks. A hold-off compare that is off by one half-line would restart on the first strobe or ignore the second.
- **Coincidence window.** It places a standard-mode strobe at 8384 and at 8385 clocks. A window shifted by one step would flag the wrong strobe. The same tests also show whether a strobe in standard mode wrongly restarts the field.
- **Mode-dependent widths.** A wrong terminal or decode constant changes the 10944-clock free run or the 608-clock blanking width. A wrongly taken blanking-width input in non-synchronous mode changes the 320-clock blanking width.

// File: rtl/tvc_pkg.sv
package tvc_pkg;

  // Default timing of a 525-line system counted in half-lines.
  localparam int unsigned TVC_HL_CLKS   = 16;   // clocks per half-line
  localparam int unsigned TVC_PRESET    = 20;   // field counter start value
  localparam int unsigned TVC_TERM_STD  = 545;  // standard terminal value
  localparam int unsigned TVC_FREE_HL   = 684;  // non-sync free-run length
  localparam int unsigned TVC_HOLD_HL   = 492;  // noise hold-off length
  localparam int unsigned TVC_RAMP_HL   = 12;   // ramp charge width
  localparam int unsigned TVC_BLANK_HL  = 38;   // standard blanking width

  typedef enum logic {
    FLD_FOLLOW = 1'b0,
    FLD_FIXED  = 1'b1
  } fld_mode_e;

  function automatic int unsigned tvc_cnt_width(input int unsigned preset,
                                                input int unsigned free_hl,
                                                input int unsigned term_std);
    int unsigned top;
    top = (preset + free_hl > term_std) ? preset + free_hl : term_std;
    return $clog2(top + 1);
  endfunction

endpackage

// File: rtl/tvc_line_div.sv
module tvc_line_div #(
  parameter int unsigned HL_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_q,
  output logic h_drive_q
);
  localparam int unsigned LINE_CLKS = 2 * HL_CLKS;
  localparam int unsigned CW        = $clog2(LINE_CLKS);
  localparam logic [CW-1:0] HALF_LAST = CW'(HL_CLKS - 1);
  localparam logic [CW-1:0] LINE_LAST = CW'(LINE_CLKS - 1);
  localparam logic [CW-1:0] HALF_C    = CW'(HL_CLKS);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      tick_q    <= 1'b0;
      h_drive_q <= 1'b1;
    end else begin
      phase     <= (phase == LINE_LAST) ? '0 : phase + 1'b1;
      tick_q    <= (phase == HALF_LAST) || (phase == LINE_LAST);
      h_drive_q <= (phase < HALF_C);
    end
  end

  // R1: enable never lasts two clocks
  a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);

  // R2: drive edges only follow a half-line enable
  a_r2_drive_on_tick: assert property (@(posedge clk) disable iff (rst)
    (h_drive_q != $past(h_drive_q)) |-> $past(tick_q));

endmodule

// File: rtl/tvc_field_ctr.sv
module tvc_field_ctr #(
  parameter int unsigned PRESET   = 20,
  parameter int unsigned TERM_STD = 545,
  parameter int unsigned FREE_HL  = 684,
  parameter int unsigned HOLD_HL  = 492,
  parameter int unsigned CW       = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          std_mode,
  input  logic          vsync,
  output logic [CW-1:0] hc,
  output logic          fs_q,
  output logic          coinc_q
);
  import tvc_pkg::*;

  localparam logic [CW-1:0] PRESET_C   = CW'(PRESET);
  localparam logic [CW-1:0] LAST_STD_C = CW'(TERM_STD - 1);
  localparam logic [CW-1:0] LAST_NS_C  = CW'(PRESET + FREE_HL - 1);
  localparam logic [CW-1:0] HOLD_AT_C  = CW'(PRESET + HOLD_HL);

  fld_mode_e     mode;
  logic [CW-1:0] last_hl;
  logic          sync_take;
  logic          wrap;
  logic          in_window;

  always_comb begin
    mode      = std_mode ? FLD_FIXED : FLD_FOLLOW;
    last_hl   = (mode == FLD_FIXED) ? LAST_STD_C : LAST_NS_C;
    sync_take = (mode == FLD_FOLLOW) && vsync && (hc >= HOLD_AT_C);
    wrap      = tick && (hc >= last_hl);
    in_window = (hc == LAST_STD_C) || (hc == PRESET_C);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc      <= PRESET_C;
      fs_q    <= 1'b0;
      coinc_q <= 1'b0;
    end else begin
      if (sync_take || wrap) begin
        hc <= PRESET_C;
      end else if (tick) begin
        hc <= hc + 1'b1;
      end
      fs_q    <= sync_take || wrap;
      coinc_q <= vsync && in_window;
    end
  end

  // R3: counter stays inside the preset..terminal span
  a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
    (hc >= PRESET_C) && (hc <= LAST_NS_C));

  // R4: in standard mode only the enable moves the counter
  a_r4_std_no_restart: assert property (@(posedge clk) disable iff (rst)
    (std_mode && !tick) |=> $stable(hc));

  // R6: an early strobe never causes a field start
  a_r6_holdoff: assert property (@(posedge clk) disable iff (rst)
    (!std_mode && vsync && !tick && (hc < HOLD_AT_C)) |=> !fs_q);

  // R10: coincidence is always caused by a strobe
  a_r10_coinc_cause: assert property (@(posedge clk) disable iff (rst)
    coinc_q |-> $past(vsync));

endmodule

// File: rtl/tvc_pulse_gen.sv
module tvc_pulse_gen #(
  parameter int unsigned PRESET   = 20,
  parameter int unsigned RAMP_HL  = 12,
  parameter int unsigned BLANK_HL = 38,
  parameter int unsigned CW       = 10,
  parameter int unsigned BW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] hc,
  input  logic          fs,
  input  logic          std_mode,
  input  logic [BW-1:0] ns_len,
  output logic          ramp_q,
  output logic          blank_q
);
  localparam int unsigned EW = ((CW > BW) ? CW : BW) + 1;
  localparam logic [EW-1:0] RAMP_END_C  = EW'(PRESET + RAMP_HL);
  localparam logic [EW-1:0] STD_BLANK_C = EW'(PRESET + BLANK_HL);
  localparam logic [EW-1:0] PRESET_C    = EW'(PRESET);

  logic [BW-1:0] len_reg;
  logic [EW-1:0] blank_end;
  logic [EW-1:0] hc_ext;

  always_comb begin
    hc_ext    = EW'(hc);
    blank_end = std_mode ? STD_BLANK_C : (PRESET_C + EW'(len_reg));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_reg <= BW'(BLANK_HL);
      ramp_q  <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      if (fs) len_reg <= ns_len;
      ramp_q  <= (hc_ext < RAMP_END_C);
      blank_q <= (hc_ext < blank_end);
    end
  end

  // R7: ramp charge starts at the field start
  a_r7_ramp_start: assert property (@(posedge clk) disable iff (rst)
    $rose(ramp_q) |-> $past(hc) == CW'(PRESET));

endmodule

// File: rtl/tv_countdown.sv
module tv_countdown #(
  parameter int unsigned HL_CLKS  = tvc_pkg::TVC_HL_CLKS,
  parameter int unsigned PRESET   = tvc_pkg::TVC_PRESET,
  parameter int unsigned TERM_STD = tvc_pkg::TVC_TERM_STD,
  parameter int unsigned FREE_HL  = tvc_pkg::TVC_FREE_HL,
  parameter int unsigned HOLD_HL  = tvc_pkg::TVC_HOLD_HL,
  parameter int unsigned RAMP_HL  = tvc_pkg::TVC_RAMP_HL,
  parameter int unsigned BLANK_HL = tvc_pkg::TVC_BLANK_HL,
  parameter int unsigned BW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          std_mode,
  input  logic          vsync_in,
  input  logic [BW-1:0] ns_blank_hl,
  output logic          hl_tick,
  output logic          h_drive,
  output logic          field_start,
  output logic          ramp_pulse,
  output logic          v_blank,
  output logic          coinc
);
  localparam int unsigned CW = tvc_pkg::tvc_cnt_width(PRESET, FREE_HL, TERM_STD);

  logic [CW-1:0] hc;
  logic          tick;
  logic          fs;

  tvc_line_div #(.HL_CLKS(HL_CLKS)) u_line (
    .clk       (clk),
    .rst       (rst),
    .tick_q    (tick),
    .h_drive_q (h_drive)
  );

  tvc_field_ctr #(
    .PRESET(PRESET), .TERM_STD(TERM_STD), .FREE_HL(FREE_HL),
    .HOLD_HL(HOLD_HL), .CW(CW)
  ) u_field (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .std_mode (std_mode),
    .vsync    (vsync_in),
    .hc       (hc),
    .fs_q     (fs),
    .coinc_q  (coinc)
  );

  tvc_pulse_gen #(
    .PRESET(PRESET), .RAMP_HL(RAMP_HL), .BLANK_HL(BLANK_HL),
    .CW(CW), .BW(BW)
  ) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .hc       (hc),
    .fs       (fs),
    .std_mode (std_mode),
    .ns_len   (ns_blank_hl),
    .ramp_q   (ramp_pulse),
    .blank_q  (v_blank)
  );

  assign hl_tick     = tick;
  assign field_start = fs;

  // R3: field start is a single-clock strobe
  a_r3_fs_single: assert property (@(posedge clk) disable iff (rst)
    field_start |=> !field_start);

  // R11: outputs leave reset quiet
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !field_start && !coinc);

endmodule

// File: tb/test_tv_countdown.sv
module test_tv_countdown;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       std_mode = 1'b1;
  logic       vsync_in = 1'b0;
  logic [7:0] ns_blank_hl = 8'd38;
  logic hl_tick, h_drive, field_start, ramp_pulse, v_blank, coinc;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;  // 50 MHz

  tv_countdown i_tv_countdown (
    .clk(clk), .rst(rst), .std_mode(std_mode), .vsync_in(vsync_in),
    .ns_blank_hl(ns_blank_hl), .hl_tick(hl_tick), .h_drive(h_drive),
    .field_start(field_start), .ramp_pulse(ramp_pulse), .v_blank(v_blank),
    .coinc(coinc)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!field_start);
  endtask

  // Runs from one field start to the next; optional strobe at offset inj.
  task automatic run_field(input int inj, output int per, output int rw,
                           output int bw, output bit cseen);
    int n = 0;
    per = -1; rw = 0; bw = 0; cseen = 1'b0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      vsync_in = (inj > 0) && (n == inj - 1);
      if (ramp_pulse) rw++;
      if (v_blank) bw++;
      if (inj > 0 && n == inj && coinc) cseen = 1'b1;
      if (field_start) begin
        per = n;
        break;
      end
    end
    vsync_in = 1'b0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(!hl_tick && !field_start && !coinc, "R11 quiet strobes", 
          {hl_tick, field_start, coinc}, 0);
    check(!ramp_pulse && !v_blank, "R11 pulses low", {ramp_pulse, v_blank}, 0);
    check(h_drive, "R11 drive high", h_drive, 1);
    rst = 1'b0;
  endtask

  task automatic t_line();
    int ticks = 0, gap_bad = 0, last = -100, highs = 0, run = 0, maxrun = 0;
    for (int i = 0; i < 96; i++) begin
      @(negedge clk);
      if (hl_tick) begin
        if (last >= 0 && i - last != 16) gap_bad++;
        last = i;
        ticks++;
      end
      if (h_drive) begin
        highs++;
        run++;
        if (run > maxrun) maxrun = run;
      end else run = 0;
    end
    check(ticks == 6, "R1 tick count", ticks, 6);
    check(gap_bad == 0, "R1 tick spacing", gap_bad, 0);
    check(highs == 48, "R2 drive duty", highs, 48);
    check(maxrun == 16, "R2 drive high run", maxrun, 16);
  endtask

  task automatic t_std();
    int per, rw, bw;
    bit cs;
    wait_fs();
    run_field(0, per, rw, bw, cs);
    check(per == 8400, "R3 std period", per, 8400);
    check(rw == 192, "R7 ramp width", rw, 192);
    check(bw == 608, "R8 std blank width", bw, 608);
    run_field(4000, per, rw, bw, cs);
    check(per == 8400, "R4 strobe mid-field", per, 8400);
    check(!cs, "R10 no coinc mid-field", cs, 0);
    run_field(8385, per, rw, bw, cs);
    check(per == 8400, "R4 strobe near end", per, 8400);
    check(cs, "R10 coinc on last half-line", cs, 1);
    run_field(8384, per, rw, bw, cs);
    check(!cs, "R10 no coinc before window", cs, 0);
  endtask

  task automatic t_ns();
    int per, rw, bw;
    bit cs;
    std_mode    = 1'b0;
    ns_blank_hl = 8'd20;
    wait_fs();
    wait_fs();
    run_field(0, per, rw, bw, cs);
    check(per == 10944, "R5 free-run period", per, 10944);
    check(bw == 320, "R9 ns blank width", bw, 320);
    check(rw == 192, "R7 ramp width ns", rw, 192);
    run_field(7872, per, rw, bw, cs);
    check(per == 10944, "R6 strobe at hold-off ignored", per, 10944);
    run_field(7873, per, rw, bw, cs);
    check(per == 7873, "R6 strobe after hold-off", per, 7873);
    wait_fs();
    run_field(9000, per, rw, bw, cs);
    check(per == 9000, "R6 late strobe restarts", per, 9000);
  endtask

  initial begin
    t_reset();
    t_line();
    t_std();
    t_ns();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule